// File: doc/BRIEF.md
# Three-Source Prioritized Interrupt Controller

This block collects interrupt requests from three sources on behalf of a 16-bit signal processor. Each source raises a one-cycle pulse that sets a sticky request flag. A flag is offered to the processor only when its own mask bit and the global enable are both set. Among the offered sources, a 3-bit ranking code picks the winner. The block presents a request line and the winner's 2-bit source index, which the processor's sequencer uses to fetch the vector.

All control sits in one 16-bit control word that software reads and writes as a whole. The control word also carries a level that signals the companion processor. Software retires a serviced request by writing 1 to that source's clear bit, in the same write that restates the rest of the configuration. The request and vector outputs are plain level signals. Like an interrupt line, they have no handshake and no back-pressure: they follow the stored state, and they change one clock after a pulse or a write is registered.

Top module: `irq3_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000, and both `irq_req_o` and `irq_vec_o` are 0.
- R2: A 1 on `irq_pulse_i[i]` at a clock edge sets request flag i. Flags 2, 1 and 0 read back at bits 15, 14 and 13. A flag stays set after the pulse ends, until it is cleared.
- R3: A write with bit 4, 3 or 2 at 1 clears flag 2, 1 or 0 respectively. A 0 in a clear bit leaves that flag as it is. Bits 4 to 0 always read back as 0.
- R4: Mask bits 12, 11 and 10 (for sources 2, 1 and 0), the global enable at bit 8, and the ranking code at bits 7 to 5 are stored on a write and read back. Written values in bits 15 to 13 are ignored.
- R5: Source i is offered when its flag, its mask bit and the global enable are all 1. `irq_req_o` is 1 exactly when some source is offered. When nothing is offered, `irq_vec_o` is 0.
- R6: The ranking code orders the sources from highest to lowest as follows: 0 gives 0,1,2; 1 gives 0,2,1; 2 gives 1,0,2; 3 gives 1,2,0; 4 gives 2,0,1; 5 gives 2,1,0. `irq_vec_o` is the offered source that ranks highest.
- R7: The reserved codes 6 and 7 rank the sources as 0,1,2.
- R8: When a pulse and a clear for the same source arrive at the same edge, the flag ends up set.
- R9: Bit 9 of the control word is stored on a write, reads back, and drives `xproc_irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pulse_i | input | 3 | Request pulses, one bit per source |
| csr_wr_i | input | 1 | Write strobe for the control word |
| csr_wdata_i | input | 16 | Write data for the control word |
| csr_rdata_o | output | 16 | Current control word |
| irq_req_o | output | 1 | An offered source exists |
| irq_vec_o | output | 2 | Index of the winning source |
| xproc_irq_o | output | 1 | Interrupt level toward the companion processor |

## Verification
The hardest case to reach is the one where a source is masked off but still pending, while the ranking favours it. The correct winner is then a lower-ranked source, and only the combined gating shows it. The vector table reaches this by setting flags through pulses and configuration through writes independently. This pairs partial mask sets with rankings that would otherwise pick the masked source, and reserved codes with partial pending sets. The same-edge race between a pulse and a clear comes from a directed step that drives both on one negedge.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned CSR_W  = 16;
  localparam int unsigned IDX_W  = $clog2(NSRC);
  localparam int unsigned CODE_W = 3;

  // field positions (decoded by the processor's software)
  localparam int unsigned FLAG_LO  = 13;
  localparam int unsigned MASK_LO  = 10;
  localparam int unsigned XPROC_B  = 9;
  localparam int unsigned GEN_B    = 8;
  localparam int unsigned CODE_LO  = 5;
  localparam int unsigned CLR_LO   = 2;
  localparam int unsigned RSVD_W   = CLR_LO;

  typedef logic [IDX_W-1:0] src_idx_t;
  typedef src_idx_t order_t [NSRC];

  // ranking: element 0 is the highest-priority source
  function automatic order_t rank_of(input logic [CODE_W-1:0] code);
    order_t o;
    case (code)
      3'd1:    begin o[0] = 2'd0; o[1] = 2'd2; o[2] = 2'd1; end
      3'd2:    begin o[0] = 2'd1; o[1] = 2'd0; o[2] = 2'd2; end
      3'd3:    begin o[0] = 2'd1; o[1] = 2'd2; o[2] = 2'd0; end
      3'd4:    begin o[0] = 2'd2; o[1] = 2'd0; o[2] = 2'd1; end
      3'd5:    begin o[0] = 2'd2; o[1] = 2'd1; o[2] = 2'd0; end
      default: begin o[0] = 2'd0; o[1] = 2'd1; o[2] = 2'd2; end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/irq3_flags.sv
module irq3_flags
  import irq3_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;   // new request wins over clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq3_cfg.sv
module irq3_cfg
  import irq3_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CSR_W-1:0]  wdata_i,
  output logic [N-1:0]      mask_o,
  output logic              gen_o,
  output logic              xproc_o,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o  <= '0;
      gen_o   <= 1'b0;
      xproc_o <= 1'b0;
      code_o  <= '0;
    end else if (wr_i) begin
      mask_o  <= wdata_i[MASK_LO +: N];
      gen_o   <= wdata_i[GEN_B];
      xproc_o <= wdata_i[XPROC_B];
      code_o  <= wdata_i[CODE_LO +: CODE_W];
    end
  end

  assign clr_o = wr_i ? wdata_i[CLR_LO +: N] : '0;
endmodule

// File: rtl/irq3_resolve.sv
module irq3_resolve
  import irq3_pkg::*;
(
  input  logic [NSRC-1:0]   offer_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              req_o,
  output src_idx_t          vec_o
);
  order_t ord;

  always_comb begin
    ord   = rank_of(code_i);
    req_o = 1'b0;
    vec_o = '0;
    // walk from lowest rank up so the highest-ranked offered source is last
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (offer_i[ord[k]]) begin
        req_o = 1'b1;
        vec_o = ord[k];
      end
    end
  end
endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
  import irq3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       irq_pulse_i,
  input  logic             csr_wr_i,
  input  logic [15:0]      csr_wdata_i,
  output logic [15:0]      csr_rdata_o,
  output logic             irq_req_o,
  output logic [1:0]       irq_vec_o,
  output logic             xproc_irq_o
);
  logic [NSRC-1:0]   flags, mask, clr, offer;
  logic              gen;
  logic [CODE_W-1:0] code;

  irq3_cfg #(.N(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(csr_wr_i), .wdata_i(csr_wdata_i),
    .mask_o(mask), .gen_o(gen), .xproc_o(xproc_irq_o), .code_o(code),
    .clr_o(clr)
  );

  irq3_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(irq_pulse_i), .clr_i(clr),
    .flags_o(flags)
  );

  assign offer = flags & mask & {NSRC{gen}};

  irq3_resolve u_res (
    .offer_i(offer), .code_i(code), .req_o(irq_req_o), .vec_o(irq_vec_o)
  );

  assign csr_rdata_o = {flags, mask, xproc_irq_o, gen, code, {NSRC{1'b0}}, {RSVD_W{1'b0}}};
endmodule

// File: rtl/irq3_ctrl_chk.sv
module irq3_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  irq_pulse_i,
  input logic        csr_wr_i,
  input logic [15:0] csr_wdata_i,
  input logic [15:0] csr_rdata_o,
  input logic        irq_req_o,
  input logic [1:0]  irq_vec_o,
  input logic        xproc_irq_o
);
  logic [2:0] sel_flag, sel_mask;
  assign sel_flag = csr_rdata_o[15:13] >> irq_vec_o;
  assign sel_mask = csr_rdata_o[12:10] >> irq_vec_o;

  AST_REQ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == ((|(csr_rdata_o[15:13] & csr_rdata_o[12:10])) && csr_rdata_o[8])); // R5
  AST_WINNER_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (sel_flag[0] && sel_mask[0])); // R6
  AST_SET_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_i[0] |=> csr_rdata_o[13]); // R8
  AST_SET_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_i[2] |=> csr_rdata_o[15]); // R2
  AST_CLEAR_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && csr_wdata_i[3] && !irq_pulse_i[1]) |=> !csr_rdata_o[14]); // R3
  AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csr_rdata_o[13]) |-> $past(csr_wr_i && csr_wdata_i[2])); // R3
  AST_XPROC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    xproc_irq_o == csr_rdata_o[9]); // R9
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> irq_vec_o == 2'd0); // R5
endmodule

bind irq3_ctrl irq3_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse_i(irq_pulse_i), .csr_wr_i(csr_wr_i),
  .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .irq_req_o(irq_req_o),
  .irq_vec_o(irq_vec_o), .xproc_irq_o(xproc_irq_o)
);

// File: tb/irq3_ctrl_test.sv
module irq3_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_pulse_i = '0;
  logic        csr_wr_i = 1'b0;
  logic [15:0] csr_wdata_i = '0;
  logic [15:0] csr_rdata_o;
  logic        irq_req_o;
  logic [1:0]  irq_vec_o;
  logic        xproc_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq3_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pulse_i(irq_pulse_i), .csr_wr_i(csr_wr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .irq_req_o(irq_req_o),
    .irq_vec_o(irq_vec_o), .xproc_irq_o(xproc_irq_o)
  );

  // {flags[2:0], mask[2:0], enable, code[2:0], exp_req, exp_vec[1:0]}
  localparam logic [12:0] VEC [17] = '{
    {3'b111, 3'b111, 1'b1, 3'd0, 1'b1, 2'd0},
    {3'b111, 3'b111, 1'b1, 3'd1, 1'b1, 2'd0},
    {3'b111, 3'b111, 1'b1, 3'd2, 1'b1, 2'd1},
    {3'b111, 3'b111, 1'b1, 3'd3, 1'b1, 2'd1},
    {3'b111, 3'b111, 1'b1, 3'd4, 1'b1, 2'd2},
    {3'b111, 3'b111, 1'b1, 3'd5, 1'b1, 2'd2},
    {3'b111, 3'b111, 1'b1, 3'd6, 1'b1, 2'd0},
    {3'b111, 3'b111, 1'b1, 3'd7, 1'b1, 2'd0},
    {3'b110, 3'b111, 1'b1, 3'd1, 1'b1, 2'd2},
    {3'b011, 3'b111, 1'b1, 3'd3, 1'b1, 2'd1},
    {3'b101, 3'b111, 1'b1, 3'd5, 1'b1, 2'd2},
    {3'b011, 3'b111, 1'b1, 3'd4, 1'b1, 2'd0},
    {3'b111, 3'b111, 1'b0, 3'd0, 1'b0, 2'd0},
    {3'b111, 3'b010, 1'b1, 3'd5, 1'b1, 2'd1},
    {3'b000, 3'b111, 1'b1, 3'd0, 1'b0, 2'd0},
    {3'b110, 3'b110, 1'b1, 3'd7, 1'b1, 2'd1},
    {3'b101, 3'b011, 1'b1, 3'd3, 1'b1, 2'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg(input logic [2:0] m, input logic x, input logic e,
                                      input logic [2:0] c, input logic [2:0] clr);
    return {3'b000, m, x, e, c, clr, 2'b00};
  endfunction

  task automatic wr(input logic [15:0] d, input logic [2:0] p);
    @(negedge clk);
    csr_wr_i = 1'b1; csr_wdata_i = d; irq_pulse_i = p;
    @(negedge clk);
    csr_wr_i = 1'b0; csr_wdata_i = '0; irq_pulse_i = '0;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk);
    irq_pulse_i = p;
    @(negedge clk);
    irq_pulse_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", csr_rdata_o, 16'h0000);
    chk("R1 req/vec", {13'd0, irq_req_o, irq_vec_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R5 R6 R7
    foreach (VEC[i]) begin
      logic [2:0] f, m, c; logic e, rq; logic [1:0] v;
      {f, m, e, c, rq, v} = VEC[i];
      wr(cfg(m, 1'b0, e, c, 3'b111), 3'b000);
      pulse(f);
      chk($sformatf("R4 readback vec%0d", i), csr_rdata_o, {f, m, 1'b0, e, c, 5'b0});
      chk($sformatf("R6 R7 R5 outputs vec%0d", i), {13'd0, irq_req_o, irq_vec_o}, {13'd0, rq, v});
    end

    // R2 flag persists long after pulse
    wr(cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b111), 3'b000);
    pulse(3'b100);
    repeat (5) @(negedge clk);
    chk("R2 sticky flag", csr_rdata_o, {3'b100, 3'b111, 1'b0, 1'b1, 3'd0, 5'b0});

    // R4 writes to flag bits ignored
    wr(16'hE000 | cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b000), 3'b000);
    chk("R4 flag bits not writable", csr_rdata_o, {3'b100, 3'b111, 1'b0, 1'b1, 3'd0, 5'b0});

    // R3 clear one flag, others stay; zero clear bits no effect; reserved reads 0
    pulse(3'b011);
    wr(cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b000) | 16'h0003, 3'b000);
    chk("R3 zero clear no effect", csr_rdata_o, {3'b111, 3'b111, 1'b0, 1'b1, 3'd0, 5'b0});
    wr(cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b010), 3'b000);
    chk("R3 clear src1 only", csr_rdata_o, {3'b101, 3'b111, 1'b0, 1'b1, 3'd0, 5'b0});
    wr(cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b001), 3'b000);
    chk("R3 clear src0 vec moves", {13'd0, irq_req_o, irq_vec_o}, {13'd0, 1'b1, 2'd2});

    // R8 pulse and clear on same edge
    wr(cfg(3'b111, 1'b0, 1'b1, 3'd0, 3'b111), 3'b001);
    chk("R8 request beats clear", csr_rdata_o, {3'b001, 3'b111, 1'b0, 1'b1, 3'd0, 5'b0});

    // R9 companion interrupt level
    wr(cfg(3'b000, 1'b1, 1'b0, 3'd0, 3'b000), 3'b000);
    chk("R9 xproc high", {15'd0, xproc_irq_o}, 16'd1);
    chk("R9 readback", csr_rdata_o & 16'h0200, 16'h0200);
    wr(cfg(3'b000, 1'b0, 1'b0, 3'd0, 3'b000), 3'b000);
    chk("R9 xproc low", {15'd0, xproc_irq_o}, 16'd0);

    finish_run();
  end
endmodule